// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller steps a small system through three levels of low-power operation and back to full operation. Software places a mode on `mode_i` and pulses `sleep_req_i`. The controller then gates the core clock (sleep), also stops the main oscillator and the peripheral clocks (stop), or switches off the core, peripheral and RAM domains (standby). An always-on register file keeps its contents in every mode.

A wake event counts only if its enable bit is set and the current mode accepts that source. Each deeper mode accepts fewer sources.
- Sleep resumes on the next cycle.
- Stop turns the oscillator back on and waits for it to report ready, with a timeout, before it releases the core clock.
- Standby brings the domains back up one at a time and holds a reset request until the sequence is complete.

A status register records which source ended the low-power period and which mode was left. Each of its bits is cleared by writing a one to it.

Top module: `lp_mode_seq`

## Requirements
- R1: With `mode_i`=2'b01 (sleep) accepted, the core clock enable drops one cycle after the request. The peripheral clock, the oscillator and all three domains stay on.
- R2: In sleep, a qualified wake event raises the core clock enable one cycle later. There is no wait for the oscillator and no reset request.
- R3: With `mode_i`=2'b10 (stop) accepted, the core clock, peripheral clock and oscillator enables are low. The core, peripheral and RAM domains stay powered and no reset is requested.
- R4: On wake from stop, the oscillator enable rises first. The core and peripheral clocks return in the cycle after the controller samples `osc_ready_i` high, and no reset is requested.
- R5: With `mode_i`=2'b11 (standby) accepted, all three domain controls and all clock enables are low and the reset request is high.
- R6: Standby exit takes one cycle per step: RAM domain on, then peripheral domain on, then core domain on, then reset request released together with the clocks.
- R7: Wake source bits are: 0 dedicated wake pin, 1 RTC alarm, 2 timer, 3 comparator, 4 general pin, 5 serial interface. Sleep accepts all six sources, stop accepts bits 0 to 4, and standby accepts bits 0 and 1 only.
- R8: `wake_cause_o` has three fields. Bits [5:0] hold the waking source as one-hot, with the lowest index taking priority when several fire together. Bits [7:6] hold the mode that was exited, in the `mode_i` encoding. Bit 8 is the oscillator-timeout flag. Writing a one to any bit clears that bit.
- R9: A sleep request is ignored, and the controller stays active, while a source that is both enabled and accepted by the requested mode is already asserted. A request with `mode_i`=2'b00 is also ignored.
- R10: If `osc_ready_i` has not been seen after `osc_limit_i` cycles of waiting on stop exit, the clocks are released anyway and cause bit 8 is set.
- R11: Backup register contents written before standby read back unchanged after the standby exit sequence.
- R12: An asserted source whose enable bit is low neither blocks entry to a mode nor wakes the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sleep_req_i | input | 1 | Request to enter the mode on `mode_i` |
| mode_i | input | 2 | 01 sleep, 10 stop, 11 standby, 00 none |
| wake_evt_i | input | 6 | Wake event per source |
| wake_en_i | input | 6 | Enable per source |
| osc_ready_i | input | 1 | Main oscillator stable |
| osc_limit_i | input | 8 | Cycles to wait for oscillator ready |
| cause_clr_we_i | input | 1 | Write strobe for clearing cause bits |
| cause_clr_i | input | 9 | Bits to clear in the cause register |
| bkp_we_i | input | 1 | Backup register write enable |
| bkp_addr_i | input | 3 | Backup register address |
| bkp_wdata_i | input | 16 | Backup register write data |
| bkp_rdata_o | output | 16 | Backup register read data |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Main oscillator enable |
| pwr_core_o | output | 1 | Core domain switch |
| pwr_periph_o | output | 1 | Peripheral domain switch |
| pwr_ram_o | output | 1 | RAM domain switch |
| rst_req_o | output | 1 | System reset request |
| wake_cause_o | output | 9 | Wake cause, exited mode, timeout flag |

## Verification
All outputs are decoded from the registered state, so they change one cycle after the edge that accepts a request or a wake event. Inputs are driven and outputs sampled on the falling edge, which means each check sees the state left by the preceding rising edge.
- Sleep entry and sleep wake results appear at the first falling edge after the request or event.
- Standby exit is checked at each of four consecutive falling edges.
- Stop exit uses a bench oscillator model with a known delay. The core clock is expected low at each of the four sampling points before the controller sees ready and high at the fifth. In the timeout case it is expected high at the sixth point, one after the limit expires.
- Cleared cause bits are expected one cycle after the write strobe.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int unsigned NSRC = 6;
  localparam int unsigned CW   = NSRC + 3;

  typedef enum logic [1:0] {
    LPM_NONE  = 2'b00,
    LPM_SLEEP = 2'b01,
    LPM_STOP  = 2'b10,
    LPM_STBY  = 2'b11
  } lpm_e;

  typedef enum logic [2:0] {
    ST_ACT, ST_SLP, ST_STOP, ST_OSCW, ST_STBY, ST_UPRAM, ST_UPPER, ST_UPCORE
  } st_e;

  // sources accepted per mode; bit 0 wake pin, 1 rtc, 2 timer, 3 cmp, 4 pin, 5 serial
  localparam logic [NSRC-1:0] MASK_SLEEP = 6'b111111;
  localparam logic [NSRC-1:0] MASK_STOP  = 6'b011111;
  localparam logic [NSRC-1:0] MASK_STBY  = 6'b000011;

  function automatic logic [NSRC-1:0] accept_mask(lpm_e m);
    unique case (m)
      LPM_SLEEP: return MASK_SLEEP;
      LPM_STOP:  return MASK_STOP;
      LPM_STBY:  return MASK_STBY;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual
  import lp_seq_pkg::*;
(
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] en_i,
  input  lpm_e            mode_i,
  output logic            hit_o,
  output logic [NSRC-1:0] first_o
);
  logic [NSRC-1:0] qual;
  logic [NSRC-1:0] mask;

  assign mask    = accept_mask(mode_i);
  assign qual    = evt_i & en_i & mask;
  assign hit_o   = |qual;
  assign first_o = qual & (~qual + {{(NSRC-1){1'b0}}, 1'b1});
endmodule

// File: rtl/lp_osc_wait.sv
module lp_osc_wait #(
  parameter int unsigned TO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            ready_i,
  input  logic [TO_W-1:0] limit_i,
  output logic            done_o,
  output logic            timeout_o
);
  logic [TO_W-1:0] cnt_q;
  logic [TO_W:0]   cnt_p1;
  logic            expired;

  assign cnt_p1  = {1'b0, cnt_q} + {{TO_W{1'b0}}, 1'b1};
  assign expired = cnt_p1 >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (!expired)  cnt_q <= cnt_p1[TO_W-1:0];
  end

  assign done_o    = active_i && (ready_i || expired);
  assign timeout_o = active_i && !ready_i && expired;
endmodule

// File: rtl/lp_backup_rf.sv
module lp_backup_rf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && (addr_i == AW'(g)))         mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_seq_pkg::*;
#(
  parameter int unsigned TO_W      = 8,
  parameter int unsigned BKP_DEPTH = 8,
  parameter int unsigned BKP_W     = 16,
  localparam int unsigned BKP_AW   = $clog2(BKP_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic [1:0]        mode_i,
  input  logic [NSRC-1:0]   wake_evt_i,
  input  logic [NSRC-1:0]   wake_en_i,
  input  logic              osc_ready_i,
  input  logic [TO_W-1:0]   osc_limit_i,
  input  logic              cause_clr_we_i,
  input  logic [CW-1:0]     cause_clr_i,
  input  logic              bkp_we_i,
  input  logic [BKP_AW-1:0] bkp_addr_i,
  input  logic [BKP_W-1:0]  bkp_wdata_i,
  output logic [BKP_W-1:0]  bkp_rdata_o,
  output logic              core_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              osc_en_o,
  output logic              pwr_core_o,
  output logic              pwr_periph_o,
  output logic              pwr_ram_o,
  output logic              rst_req_o,
  output logic [CW-1:0]     wake_cause_o
);
  st_e             st_q, st_d;
  lpm_e            qmode;
  logic            hit;
  logic [NSRC-1:0] first;
  logic            osc_done, osc_to;
  logic            take;
  logic [CW-1:0]   cause_q, cause_d;

  always_comb begin
    unique case (st_q)
      ST_ACT:  qmode = lpm_e'(mode_i);
      ST_SLP:  qmode = LPM_SLEEP;
      ST_STOP: qmode = LPM_STOP;
      ST_STBY: qmode = LPM_STBY;
      default: qmode = LPM_NONE;
    endcase
  end

  lp_wake_qual u_qual (
    .evt_i   (wake_evt_i),
    .en_i    (wake_en_i),
    .mode_i  (qmode),
    .hit_o   (hit),
    .first_o (first)
  );

  lp_osc_wait #(.TO_W(TO_W)) u_osc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (st_q == ST_OSCW),
    .ready_i   (osc_ready_i),
    .limit_i   (osc_limit_i),
    .done_o    (osc_done),
    .timeout_o (osc_to)
  );

  lp_backup_rf #(.DEPTH(BKP_DEPTH), .DW(BKP_W)) u_bkp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bkp_we_i),
    .addr_i  (bkp_addr_i),
    .wdata_i (bkp_wdata_i),
    .rdata_o (bkp_rdata_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACT: begin
        // entry refused while a qualified event is pending
        if (sleep_req_i && !hit) begin
          unique case (lpm_e'(mode_i))
            LPM_SLEEP: st_d = ST_SLP;
            LPM_STOP:  st_d = ST_STOP;
            LPM_STBY:  st_d = ST_STBY;
            default:   st_d = ST_ACT;
          endcase
        end
      end
      ST_SLP:    if (hit) st_d = ST_ACT;
      ST_STOP:   if (hit) st_d = ST_OSCW;
      ST_OSCW:   if (osc_done) st_d = ST_ACT;
      ST_STBY:   if (hit) st_d = ST_UPRAM;
      ST_UPRAM:  st_d = ST_UPPER;
      ST_UPPER:  st_d = ST_UPCORE;
      ST_UPCORE: st_d = ST_ACT;
      default:   st_d = ST_ACT;
    endcase
  end

  assign take = hit && (st_q == ST_SLP || st_q == ST_STOP || st_q == ST_STBY);

  always_comb begin
    cause_d = cause_q;
    if (cause_clr_we_i) cause_d = cause_d & ~cause_clr_i;
    if (take) begin
      cause_d[NSRC-1:0]    = first;
      cause_d[NSRC+1:NSRC] = qmode;
    end
    if (osc_to) cause_d[NSRC+2] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ACT;
      cause_q <= '0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
    end
  end

  assign core_clk_en_o   = (st_q == ST_ACT);
  assign periph_clk_en_o = (st_q == ST_ACT) || (st_q == ST_SLP);
  assign osc_en_o        = !(st_q == ST_STOP || st_q == ST_STBY);
  assign pwr_ram_o       = (st_q != ST_STBY);
  assign pwr_periph_o    = !(st_q == ST_STBY || st_q == ST_UPRAM);
  assign pwr_core_o      = !(st_q == ST_STBY || st_q == ST_UPRAM || st_q == ST_UPPER);
  assign rst_req_o       = (st_q == ST_STBY) || (st_q == ST_UPRAM) ||
                           (st_q == ST_UPPER) || (st_q == ST_UPCORE);
  assign wake_cause_o    = cause_q;
endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk
  import lp_seq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          core_clk_en_o,
  input logic          periph_clk_en_o,
  input logic          osc_en_o,
  input logic          pwr_core_o,
  input logic          pwr_periph_o,
  input logic          pwr_ram_o,
  input logic          rst_req_o,
  input logic [CW-1:0] wake_cause_o
);
  AST_PERIPH_NEEDS_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_periph_o |-> pwr_ram_o); // R6
  AST_CORE_NEEDS_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_core_o |-> pwr_periph_o); // R6
  AST_CORE_DOMAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_core_o) |-> $past(pwr_periph_o)); // R6
  AST_CLK_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clk_en_o || periph_clk_en_o) |-> osc_en_o); // R4
  AST_CORE_RISE_AFTER_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) |-> $past(osc_en_o)); // R4
  AST_RST_HOLDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !core_clk_en_o); // R5
  AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wake_cause_o[NSRC-1:0])); // R8
endmodule

bind lp_mode_seq lp_mode_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .core_clk_en_o   (core_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .osc_en_o        (osc_en_o),
  .pwr_core_o      (pwr_core_o),
  .pwr_periph_o    (pwr_periph_o),
  .pwr_ram_o       (pwr_ram_o),
  .rst_req_o       (rst_req_o),
  .wake_cause_o    (wake_cause_o)
);

// File: tb/lp_mode_seq_tb_top.sv
module lp_mode_seq_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [5:0]  evt = '0;
  logic [5:0]  en = '0;
  logic        osc_rdy;
  logic [7:0]  osc_limit = 8'd20;
  logic        clr_we = 1'b0;
  logic [8:0]  clr = '0;
  logic        bkp_we = 1'b0;
  logic [2:0]  bkp_addr = '0;
  logic [15:0] bkp_wdata = '0;
  logic [15:0] bkp_rdata;
  logic core_clk, per_clk, osc_en, p_core, p_per, p_ram, rst_req;
  logic [8:0]  cause;

  int checks = 0;
  int errors = 0;
  int osc_dly = 3;
  int ocnt = 0;

  always #(CLK_P/2) clk = ~clk;

  // oscillator model: ready osc_dly edges after enable rises
  always @(posedge clk) begin
    if (!osc_en) ocnt <= 0;
    else         ocnt <= ocnt + 1;
  end
  assign osc_rdy = osc_en && (ocnt >= osc_dly);

  lp_mode_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .mode_i(mode),
    .wake_evt_i(evt), .wake_en_i(en), .osc_ready_i(osc_rdy), .osc_limit_i(osc_limit),
    .cause_clr_we_i(clr_we), .cause_clr_i(clr), .bkp_we_i(bkp_we),
    .bkp_addr_i(bkp_addr), .bkp_wdata_i(bkp_wdata), .bkp_rdata_o(bkp_rdata),
    .core_clk_en_o(core_clk), .periph_clk_en_o(per_clk), .osc_en_o(osc_en),
    .pwr_core_o(p_core), .pwr_periph_o(p_per), .pwr_ram_o(p_ram),
    .rst_req_o(rst_req), .wake_cause_o(cause)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {core_clk, per_clk, osc, p_core, p_per, p_ram, rst_req}
  function automatic logic [31:0] outs();
    return {25'd0, core_clk, per_clk, osc_en, p_core, p_per, p_ram, rst_req};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_cause();
    clr_we = 1'b1; clr = '1;
    step();
    clr_we = 1'b0; clr = '0;
    chk("R8 w1c clear", {23'd0, cause}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", outs(), 32'b1111110);
    chk("R8 reset cause", {23'd0, cause}, 32'h0);
  endtask

  task automatic t_sleep();
    en = '1; evt = '0; mode = 2'b01; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R1 sleep gating", outs(), 32'b0111110);
    evt = 6'b100000;
    step();
    evt = '0;
    chk("R2 sleep wake next cycle", outs(), 32'b1111110);
    chk("R8 cause serial+sleep", {23'd0, cause}, {23'd0, 3'b001, 6'b100000});
    clear_cause();
  endtask

  task automatic t_pending();
    en = '1; evt = 6'b010000; mode = 2'b10; sleep_req = 1'b1;
    step();
    step();
    sleep_req = 1'b0; evt = '0;
    chk("R9 request ignored when pending", outs(), 32'b1111110);
    mode = 2'b00; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R9 mode none ignored", outs(), 32'b1111110);
  endtask

  task automatic t_disabled();
    en = 6'b011111; evt = 6'b100000; mode = 2'b01; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R12 disabled source no block", outs(), 32'b0111110);
    step(); step();
    chk("R12 disabled source no wake", outs(), 32'b0111110);
    en = 6'b100000;
    step();
    evt = '0;
    chk("R12 enabled source wakes", outs(), 32'b1111110);
    clear_cause();
  endtask

  task automatic t_stop(bit timeout);
    osc_dly = timeout ? 100 : 3;
    osc_limit = 8'd5;
    en = '1; evt = 6'b100000; mode = 2'b10; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R3 stop outputs", outs(), 32'b0001110);
    step();
    chk("R7 serial ignored in stop", outs(), 32'b0001110);
    evt = 6'b001000;
    step();
    evt = '0;
    chk("R4 osc enabled first", outs(), 32'b0011110);
    for (int i = 0; i < (timeout ? 4 : 3); i++) begin
      step();
      chk("R4 core held until ready", {31'd0, core_clk}, 32'd0);
    end
    step();
    chk(timeout ? "R10 released after limit" : "R4 released after ready", outs(), 32'b1111110);
    chk(timeout ? "R10 cause timeout flag" : "R8 cause cmp+stop", {23'd0, cause},
        {23'd0, timeout, 2'b10, 6'b001000});
    clear_cause();
    osc_dly = 3; osc_limit = 8'd20;
  endtask

  task automatic t_standby();
    bkp_we = 1'b1; bkp_addr = 3'd5; bkp_wdata = 16'hC3A7;
    step();
    bkp_addr = 3'd2; bkp_wdata = 16'h5E11;
    step();
    bkp_we = 1'b0;
    en = '1; evt = 6'b000100; mode = 2'b11; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R5 standby outputs", outs(), 32'b0000001);
    step(); step();
    chk("R7 timer ignored in standby", outs(), 32'b0000001);
    evt = 6'b000010;
    step();
    evt = '0;
    chk("R6 ram first", outs(), 32'b0010011);
    step();
    chk("R6 periph second", outs(), 32'b0010111);
    step();
    chk("R6 core third", outs(), 32'b0011111);
    step();
    chk("R6 reset released", outs(), 32'b1111110);
    chk("R8 cause rtc+standby", {23'd0, cause}, {23'd0, 3'b011, 6'b000010});
    bkp_addr = 3'd5;
    #1 chk("R11 backup word 5", {16'd0, bkp_rdata}, 32'hC3A7);
    bkp_addr = 3'd2;
    #1 chk("R11 backup word 2", {16'd0, bkp_rdata}, 32'h5E11);
    clear_cause();
  endtask

  task automatic t_priority();
    en = '1; evt = '0; mode = 2'b01; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    evt = 6'b001100;
    step();
    evt = '0;
    chk("R8 lowest index wins", {23'd0, cause}, {23'd0, 3'b001, 6'b000100});
    clear_cause();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step(); step();
    t_reset();
    t_sleep();
    t_pending();
    t_disabled();
    t_stop(1'b0);
    t_stop(1'b1);
    t_standby();
    t_priority();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule